// File: doc/BRIEF.md
# Branch and Jump Resolution Unit

This unit settles the outcome of a control-transfer instruction. Given the 32-bit instruction word, the address of that instruction and the two source register values, it reports whether control leaves the sequential path, the address execution continues at, and whether a return address is to be written, to which register and with which value. It handles the conditional branches (two-register equality tests and signed tests of one register against zero), the unconditional branch that links, absolute jumps inside the current 256 MiB region, jumps through a register, and the linking forms of the jumps.

Decoding, condition evaluation and address formation are combinational. One register stage at the output holds the result, so the result for an instruction presented before a rising clock edge appears just after that edge. Pipeline flushing and delay-slot handling are left to the surrounding core. Any word that is not a recognised control transfer yields the sequential next address and no link write.

Top module: `bjr_resolve`

## Requirements
- R1: While `rst_n` is low, and at the first rising edge after it rises, `taken`, `link_we`, `target`, `link_idx` and `link_val` are all zero.
- R2: Outputs change only at a rising clock edge and reflect the inputs sampled at that edge. Between edges they hold their values whatever the inputs do.
- R3: Opcode `instr[31:26]`=000100 is taken when `rs_val == rt_val`. Opcode 000101 is taken when they differ. When taken, the target is `pc + (sign_extend(instr[15:0]) << 2)`.
- R4: Opcode 000110 with `instr[20:16]`=00000 is taken when `rs_val`, read as signed, is at most zero. Opcode 000111 with `instr[20:16]`=00000 is taken when it is above zero. The target is formed as in R3.
- R5: Opcode 000001 with `instr[20:16]`=00000 is taken when signed `rs_val` is below zero. With `instr[20:16]`=00001 it is taken when signed `rs_val` is at least zero. The target is formed as in R3.
- R6: Opcode 000001 with `instr[20:16]`=10001 and `instr[25:21]`=00000 is always taken, with the R3 target. It sets `link_we`, with `link_idx`=31 and `link_val`=`pc`+8.
- R7: Opcodes 000010 and 000011 are always taken, with target `{pc[31:28], instr[25:0], 2'b00}`. Opcode 000011 also sets `link_we`, with `link_idx`=31 and `link_val`=`pc`+8.
- R8: Opcode 000000 with function `instr[5:0]`=001000 is taken with target `rs_val` and no link. Function 001001 does the same and also sets `link_we`, with `link_idx`=`instr[15:11]` and `link_val`=`pc`+8.
- R9: Whenever `taken` is low, `target` is `pc`+4. Whenever `link_we` is low, `link_idx` and `link_val` are zero. A word that is not a control transfer gives `taken`=0 and `link_we`=0.
- R10: Malformed variants are treated as non-transfers (R9). These are opcode 000110 or 000111 with a nonzero `instr[20:16]`, opcode 000001 with any `instr[20:16]` other than 00000, 00001 or 10001, and opcode 000001 with 10001 in that field but a nonzero `instr[25:21]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| instr | input | 32 | Instruction word to resolve |
| pc | input | 32 | Address of that instruction |
| rs_val | input | 32 | Value of the register named by instr[25:21] |
| rt_val | input | 32 | Value of the register named by instr[20:16] |
| taken | output | 1 | Control leaves the sequential path |
| target | output | 32 | Next address of execution |
| link_we | output | 1 | A return address is to be written |
| link_idx | output | 5 | Register that receives the return address |
| link_val | output | 32 | Return address, instruction address plus 8 |

## Verification
A wrong decoded class or a wrong condition shows at the ports one edge after the instruction is presented. It appears as a flipped `taken`, as a target equal to the sequential address instead of the branch address or the reverse, or as a link write where none belongs. The signed tests against zero are the likely place for an error, so stimulus concentrates `rs_val` on zero, minus one, one and the two extreme values. Branch offsets include both signs and the extreme sign-extended values, so a sign-extension or shift error moves the target by a visible amount in the same cycle. Malformed field values are mixed into the random stream, so a decoder that accepts too much shows up as a spurious `taken` or `link_we`.

// File: rtl/bjr_pkg.sv
// Shared constants and types for the branch and jump resolution unit.
// Assumes the fixed 32-bit instruction layout: opcode in the top six bits,
// two register fields below it, a 16-bit offset or 26-bit index at the bottom.
package bjr_pkg;

    localparam int XLEN     = 32;
    localparam int IW       = 32;
    localparam int RIDX_W   = 5;
    localparam int OFF_W    = 16;
    localparam int IDX_W    = 26;
    localparam int OP_W     = 6;
    localparam int FN_W     = 6;
    localparam int REGION_W = XLEN - IDX_W - 2;

    localparam logic [OP_W-1:0] OP_SPECIAL = 6'b000000;
    localparam logic [OP_W-1:0] OP_REGIMM  = 6'b000001;
    localparam logic [OP_W-1:0] OP_JMP     = 6'b000010;
    localparam logic [OP_W-1:0] OP_JMPL    = 6'b000011;
    localparam logic [OP_W-1:0] OP_BREQ    = 6'b000100;
    localparam logic [OP_W-1:0] OP_BRNE    = 6'b000101;
    localparam logic [OP_W-1:0] OP_BRLEZ   = 6'b000110;
    localparam logic [OP_W-1:0] OP_BRGTZ   = 6'b000111;

    localparam logic [FN_W-1:0] FN_RJMP    = 6'b001000;
    localparam logic [FN_W-1:0] FN_RJMPL   = 6'b001001;

    localparam logic [RIDX_W-1:0] SEL_LTZ  = 5'b00000;
    localparam logic [RIDX_W-1:0] SEL_GEZ  = 5'b00001;
    localparam logic [RIDX_W-1:0] SEL_BRL  = 5'b10001;

    localparam logic [RIDX_W-1:0] LINK_REG = 5'd31;

    typedef enum logic [3:0] {
        K_NONE,
        K_BREQ,
        K_BRNE,
        K_BRLEZ,
        K_BRGTZ,
        K_BRLTZ,
        K_BRGEZ,
        K_BRLINK,
        K_JMP,
        K_JMPL,
        K_RJMP,
        K_RJMPL
    } xfer_kind_t;

    typedef struct packed {
        xfer_kind_t             kind;
        logic [RIDX_W-1:0]      rd;
        logic [OFF_W-1:0]       off;
        logic [IDX_W-1:0]       idx;
    } xfer_dec_t;

endpackage

// File: rtl/bjr_decode.sv
// Instruction classifier: maps an instruction word to one control-transfer
// kind plus the fields the address stage needs. Assumes nothing about the
// register values; any unrecognised or malformed encoding maps to K_NONE.
module bjr_decode
    import bjr_pkg::*;
(
    input  logic [IW-1:0] instr,
    output xfer_dec_t     dec
);

    logic [OP_W-1:0]   op_f;
    logic [RIDX_W-1:0] rs_f;
    logic [RIDX_W-1:0] rt_f;
    logic [FN_W-1:0]   fn_f;
    logic              unused_shamt;

    assign op_f         = instr[31:26];
    assign rs_f         = instr[25:21];
    assign rt_f         = instr[20:16];
    assign fn_f         = instr[5:0];
    assign unused_shamt = ^instr[10:6];

    // Pick the transfer kind from opcode and the selector fields.
    always_comb begin
        dec.kind = K_NONE;
        dec.rd   = instr[15:11];
        dec.off  = instr[OFF_W-1:0];
        dec.idx  = instr[IDX_W-1:0];
        case (op_f)
            OP_BREQ:  dec.kind = K_BREQ;
            OP_BRNE:  dec.kind = K_BRNE;
            OP_BRLEZ: dec.kind = (rt_f == '0) ? K_BRLEZ : K_NONE;
            OP_BRGTZ: dec.kind = (rt_f == '0) ? K_BRGTZ : K_NONE;
            OP_JMP:   dec.kind = K_JMP;
            OP_JMPL:  dec.kind = K_JMPL;
            OP_REGIMM: begin
                if (rt_f == SEL_LTZ)
                    dec.kind = K_BRLTZ;
                else if (rt_f == SEL_GEZ)
                    dec.kind = K_BRGEZ;
                else if (rt_f == SEL_BRL && rs_f == '0)
                    dec.kind = K_BRLINK;
                else
                    dec.kind = K_NONE;
            end
            OP_SPECIAL: begin
                if (fn_f == FN_RJMP)
                    dec.kind = K_RJMP;
                else if (fn_f == FN_RJMPL)
                    dec.kind = K_RJMPL;
                else
                    dec.kind = K_NONE;
            end
            default: dec.kind = K_NONE;
        endcase
    end

endmodule

// File: rtl/bjr_cond.sv
// Condition evaluator: decides whether the decoded transfer is taken.
// Tests against zero read rs as a two's-complement value; unconditional
// kinds are always taken and K_NONE never is.
module bjr_cond
    import bjr_pkg::*;
(
    input  xfer_kind_t      kind,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    output logic            take
);

    logic rs_neg;
    logic rs_zero;
    logic regs_eq;

    assign rs_neg  = rs_val[XLEN-1];
    assign rs_zero = (rs_val == '0);
    assign regs_eq = (rs_val == rt_val);

    // Evaluate the per-kind condition.
    always_comb begin
        case (kind)
            K_BREQ:   take = regs_eq;
            K_BRNE:   take = !regs_eq;
            K_BRLEZ:  take = rs_neg || rs_zero;
            K_BRGTZ:  take = !rs_neg && !rs_zero;
            K_BRLTZ:  take = rs_neg;
            K_BRGEZ:  take = !rs_neg;
            K_BRLINK,
            K_JMP,
            K_JMPL,
            K_RJMP,
            K_RJMPL:  take = 1'b1;
            default:  take = 1'b0;
        endcase
    end

endmodule

// File: rtl/bjr_addr.sv
// Address former: builds the next address and the link write from the
// decoded fields. Assumes take already reflects the condition; a not-taken
// result always falls through to pc+4 and a missing link drives zeros.
module bjr_addr
    import bjr_pkg::*;
(
    input  xfer_dec_t       dec,
    input  logic            take,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] rs_val,
    output logic [XLEN-1:0] target,
    output logic            link_we,
    output logic [RIDX_W-1:0] link_idx,
    output logic [XLEN-1:0] link_val
);

    localparam int SEXT_W = XLEN - OFF_W - 2;

    logic [XLEN-1:0] seq_addr;
    logic [XLEN-1:0] rel_addr;
    logic [XLEN-1:0] region_addr;
    logic [XLEN-1:0] ret_addr;

    assign seq_addr    = pc + XLEN'(4);
    assign ret_addr    = pc + XLEN'(8);
    assign rel_addr    = pc + {{SEXT_W{dec.off[OFF_W-1]}}, dec.off, 2'b00};
    assign region_addr = {pc[XLEN-1 -: REGION_W], dec.idx, 2'b00};

    // Choose the destination by kind, falling through when not taken.
    always_comb begin
        target = seq_addr;
        if (take) begin
            case (dec.kind)
                K_JMP, K_JMPL:   target = region_addr;
                K_RJMP, K_RJMPL: target = rs_val;
                K_NONE:          target = seq_addr;
                default:         target = rel_addr;
            endcase
        end
    end

    // Produce the return-address write for the linking kinds.
    always_comb begin
        link_we  = 1'b0;
        link_idx = '0;
        link_val = '0;
        case (dec.kind)
            K_BRLINK, K_JMPL: begin
                link_we  = 1'b1;
                link_idx = LINK_REG;
                link_val = ret_addr;
            end
            K_RJMPL: begin
                link_we  = 1'b1;
                link_idx = dec.rd;
                link_val = ret_addr;
            end
            default: begin
                link_we  = 1'b0;
                link_idx = '0;
                link_val = '0;
            end
        endcase
    end

endmodule

// File: rtl/bjr_resolve.sv
// Branch and jump resolution unit, top level. Decodes the instruction,
// evaluates its condition, forms the next address and link write, and
// registers all results once. Assumes rs_val/rt_val belong to the
// instruction presented in the same cycle.
module bjr_resolve
    import bjr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IW-1:0]     instr,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   rs_val,
    input  logic [XLEN-1:0]   rt_val,
    output logic              taken,
    output logic [XLEN-1:0]   target,
    output logic              link_we,
    output logic [RIDX_W-1:0] link_idx,
    output logic [XLEN-1:0]   link_val
);

    xfer_dec_t         dec;
    logic              take_c;
    logic [XLEN-1:0]   target_c;
    logic              link_we_c;
    logic [RIDX_W-1:0] link_idx_c;
    logic [XLEN-1:0]   link_val_c;

    bjr_decode u_decode (
        .instr (instr),
        .dec   (dec)
    );

    bjr_cond u_cond (
        .kind   (dec.kind),
        .rs_val (rs_val),
        .rt_val (rt_val),
        .take   (take_c)
    );

    bjr_addr u_addr (
        .dec      (dec),
        .take     (take_c),
        .pc       (pc),
        .rs_val   (rs_val),
        .target   (target_c),
        .link_we  (link_we_c),
        .link_idx (link_idx_c),
        .link_val (link_val_c)
    );

    // Output register stage with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken    <= 1'b0;
            target   <= '0;
            link_we  <= 1'b0;
            link_idx <= '0;
            link_val <= '0;
        end else begin
            taken    <= take_c;
            target   <= target_c;
            link_we  <= link_we_c;
            link_idx <= link_idx_c;
            link_val <= link_val_c;
        end
    end

endmodule

// File: rtl/bjr_resolve_chk.sv
// Property checker for bjr_resolve, attached by bind. Relates each
// registered output to the inputs sampled one edge earlier; a primed flag
// keeps every check off until one full cycle has passed out of reset.
module bjr_resolve_chk
    import bjr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [IW-1:0]     instr,
    input logic [XLEN-1:0]   pc,
    input logic [XLEN-1:0]   rs_val,
    input logic [XLEN-1:0]   rt_val,
    input logic              taken,
    input logic [XLEN-1:0]   target,
    input logic              link_we,
    input logic [RIDX_W-1:0] link_idx,
    input logic [XLEN-1:0]   link_val
);

    logic primed;

    // Mark that the previous edge was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !primed |-> (!taken && !link_we && target == '0 && link_idx == '0 && link_val == '0));

    a_r2_link_value: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && link_we) |-> link_val == $past(pc) + XLEN'(8));

    a_r3_equal_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(instr[31:26] == OP_BREQ && rs_val == rt_val)) |-> taken);

    a_r6_branch_link: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(instr[31:26] == OP_REGIMM && instr[20:16] == SEL_BRL
                         && instr[25:21] == '0))
        |-> (taken && link_we && link_idx == LINK_REG));

    a_r7_region_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(instr[31:27] == 5'b00001))
        |-> (taken && target == {$past(pc[31:28]), $past(instr[25:0]), 2'b00}));

    a_r8_reg_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(instr[31:26] == OP_SPECIAL && instr[5:0] == FN_RJMP))
        |-> (taken && target == $past(rs_val) && !link_we));

    a_r9_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !taken) |-> target == $past(pc) + XLEN'(4));

    a_r9_quiet_link: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !link_we) |-> (link_idx == '0 && link_val == '0));

endmodule

bind bjr_resolve bjr_resolve_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .instr    (instr),
    .pc       (pc),
    .rs_val   (rs_val),
    .rt_val   (rt_val),
    .taken    (taken),
    .target   (target),
    .link_we  (link_we),
    .link_idx (link_idx),
    .link_val (link_val)
);

// File: tb/bjr_resolve_test.sv
`timescale 1ns/1ps
// Bench for bjr_resolve: directed corner cases followed by seeded random
// vectors, each compared with a reference model written from the brief.
module bjr_resolve_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] pc = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic        taken;
    logic [31:0] target;
    logic        link_we;
    logic [4:0]  link_idx;
    logic [31:0] link_val;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct packed {
        logic        tk;
        logic [31:0] tg;
        logic        we;
        logic [4:0]  ix;
        logic [31:0] lv;
    } res_t;

    bjr_resolve uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .instr    (instr),
        .pc       (pc),
        .rs_val   (rs_val),
        .rt_val   (rt_val),
        .taken    (taken),
        .target   (target),
        .link_we  (link_we),
        .link_idx (link_idx),
        .link_val (link_val)
    );

    always #2.5 clk = ~clk;

    function automatic logic [31:0] mk_i(input logic [5:0] op, input logic [4:0] a,
                                         input logic [4:0] b, input logic [15:0] imm);
        return {op, a, b, imm};
    endfunction

    function automatic logic [31:0] mk_r(input logic [4:0] a, input logic [4:0] b,
                                         input logic [4:0] d, input logic [5:0] fn);
        return {6'b000000, a, b, d, 5'b00000, fn};
    endfunction

    // Reference model written from requirements R3..R10.
    function automatic res_t model(input logic [31:0] ins, input logic [31:0] p,
                                   input logic [31:0] a, input logic [31:0] b);
        res_t r;
        logic [31:0] rel;
        rel = p + {{14{ins[15]}}, ins[15:0], 2'b00};
        r = '{tk: 1'b0, tg: p + 32'd4, we: 1'b0, ix: 5'd0, lv: 32'd0};
        case (ins[31:26])
            6'd4: if (a == b) begin r.tk = 1'b1; r.tg = rel; end
            6'd5: if (a != b) begin r.tk = 1'b1; r.tg = rel; end
            6'd6: if (ins[20:16] == 5'd0 && $signed(a) <= 0) begin r.tk = 1'b1; r.tg = rel; end
            6'd7: if (ins[20:16] == 5'd0 && $signed(a) > 0) begin r.tk = 1'b1; r.tg = rel; end
            6'd1: begin
                if (ins[20:16] == 5'd0 && $signed(a) < 0) begin r.tk = 1'b1; r.tg = rel; end
                if (ins[20:16] == 5'd1 && $signed(a) >= 0) begin r.tk = 1'b1; r.tg = rel; end
                if (ins[20:16] == 5'd17 && ins[25:21] == 5'd0) begin
                    r.tk = 1'b1; r.tg = rel; r.we = 1'b1; r.ix = 5'd31; r.lv = p + 32'd8;
                end
            end
            6'd2, 6'd3: begin
                r.tk = 1'b1;
                r.tg = {p[31:28], ins[25:0], 2'b00};
                if (ins[26]) begin r.we = 1'b1; r.ix = 5'd31; r.lv = p + 32'd8; end
            end
            6'd0: begin
                if (ins[5:0] == 6'd8) begin r.tk = 1'b1; r.tg = a; end
                if (ins[5:0] == 6'd9) begin
                    r.tk = 1'b1; r.tg = a; r.we = 1'b1; r.ix = ins[15:11]; r.lv = p + 32'd8;
                end
            end
            default: ;
        endcase
        return r;
    endfunction

    function automatic string tag_of(input logic [31:0] ins);
        case (ins[31:26])
            6'd4, 6'd5: return "R3";
            6'd6, 6'd7: return (ins[20:16] == 5'd0) ? "R4" : "R10";
            6'd1: begin
                if (ins[20:16] == 5'd0 || ins[20:16] == 5'd1) return "R5";
                if (ins[20:16] == 5'd17 && ins[25:21] == 5'd0) return "R6";
                return "R10";
            end
            6'd2, 6'd3: return "R7";
            6'd0: return (ins[5:0] == 6'd8 || ins[5:0] == 6'd9) ? "R8" : "R9";
            default: return "R9";
        endcase
    endfunction

    task automatic compare(input string req, input res_t e);
        n_tests++;
        if (taken !== e.tk || target !== e.tg || link_we !== e.we ||
            link_idx !== e.ix || link_val !== e.lv) begin
            n_fail++;
            $display("FAIL %s: actual tk=%0b tg=%h we=%0b ix=%0d lv=%h expected tk=%0b tg=%h we=%0b ix=%0d lv=%h",
                     req, taken, target, link_we, link_idx, link_val,
                     e.tk, e.tg, e.we, e.ix, e.lv);
        end
    endtask

    // Present one vector, let one edge capture it, then check.
    task automatic run_vec(input string req, input logic [31:0] ins, input logic [31:0] p,
                           input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        instr = ins; pc = p; rs_val = a; rt_val = b;
        @(negedge clk);
        compare(req, model(ins, p, a, b));
    endtask

    function automatic logic [31:0] pick_val();
        case ($urandom % 8)
            0: return 32'h0000_0000;
            1: return 32'hFFFF_FFFF;
            2: return 32'h8000_0000;
            3: return 32'h0000_0001;
            4: return 32'h7FFF_FFFF;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int seed_set;
        res_t ea;
        seed_set = $urandom(32'h0BAD_5EED);

        // R1: reset holds every output at zero even with a linking jump present.
        instr = mk_i(6'd3, 5'd1, 5'd2, 16'h1234); pc = 32'h4000_0000;
        repeat (3) @(negedge clk);
        compare("R1", '0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        compare("R1", model(instr, pc, rs_val, rt_val));

        // R3: equality branches, both offset signs and extremes.
        run_vec("R3", mk_i(6'd4, 5'd1, 5'd2, 16'h0010), 32'h0000_1000, 32'd5, 32'd5);
        run_vec("R3", mk_i(6'd4, 5'd1, 5'd2, 16'hFFF0), 32'h0000_1000, 32'd5, 32'd6);
        run_vec("R3", mk_i(6'd4, 5'd1, 5'd2, 16'h8000), 32'h0010_0000, 32'h8000_0000, 32'h8000_0000);
        run_vec("R3", mk_i(6'd5, 5'd1, 5'd2, 16'h7FFF), 32'h0010_0000, 32'hFFFF_FFFF, 32'h0);
        run_vec("R3", mk_i(6'd5, 5'd1, 5'd2, 16'hFFFF), 32'h0010_0000, 32'd7, 32'd7);

        // R4: tests against zero at 0, -1, 1 and both extremes.
        run_vec("R4", mk_i(6'd6, 5'd3, 5'd0, 16'h0004), 32'h2000, 32'h0, 32'h0);
        run_vec("R4", mk_i(6'd6, 5'd3, 5'd0, 16'hFFFC), 32'h2000, 32'hFFFF_FFFF, 32'h0);
        run_vec("R4", mk_i(6'd6, 5'd3, 5'd0, 16'h0004), 32'h2000, 32'h0000_0001, 32'h0);
        run_vec("R4", mk_i(6'd6, 5'd3, 5'd0, 16'h0004), 32'h2000, 32'h8000_0000, 32'h0);
        run_vec("R4", mk_i(6'd7, 5'd3, 5'd0, 16'h0004), 32'h2000, 32'h0, 32'h0);
        run_vec("R4", mk_i(6'd7, 5'd3, 5'd0, 16'hFFFC), 32'h2000, 32'h0000_0001, 32'h0);
        run_vec("R4", mk_i(6'd7, 5'd3, 5'd0, 16'h0100), 32'h2000, 32'h7FFF_FFFF, 32'h0);
        run_vec("R4", mk_i(6'd7, 5'd3, 5'd0, 16'h0100), 32'h2000, 32'h8000_0000, 32'h0);

        // R5: signed less-than and at-least zero.
        run_vec("R5", mk_i(6'd1, 5'd4, 5'd0, 16'h0020), 32'h3000, 32'hFFFF_FFFF, 32'h0);
        run_vec("R5", mk_i(6'd1, 5'd4, 5'd0, 16'h0020), 32'h3000, 32'h0, 32'h0);
        run_vec("R5", mk_i(6'd1, 5'd4, 5'd0, 16'hFFE0), 32'h3000, 32'h8000_0000, 32'h0);
        run_vec("R5", mk_i(6'd1, 5'd4, 5'd1, 16'hFFE0), 32'h3000, 32'h0, 32'h0);
        run_vec("R5", mk_i(6'd1, 5'd4, 5'd1, 16'h0020), 32'h3000, 32'hFFFF_FFFF, 32'h0);

        // R6: unconditional branch with link, negative offset.
        run_vec("R6", mk_i(6'd1, 5'd0, 5'd17, 16'hFFF8), 32'h0000_8000, 32'h8000_0000, 32'h0);

        // R7: region jumps keep the upper four address bits.
        run_vec("R7", {6'd2, 26'h3FF_FFFF}, 32'hA123_4560, 32'h0, 32'h0);
        run_vec("R7", {6'd3, 26'h000_0001}, 32'h5FFF_FFFC, 32'h0, 32'h0);

        // R8: register jumps, plain and linking to rd.
        run_vec("R8", mk_r(5'd9, 5'd0, 5'd0, 6'd8), 32'h100, 32'hDEAD_BEEC, 32'h0);
        run_vec("R8", mk_r(5'd9, 5'd0, 5'd5, 6'd9), 32'h100, 32'h0000_4000, 32'h0);

        // R9: non-transfer words fall through with no link.
        run_vec("R9", mk_r(5'd1, 5'd2, 5'd3, 6'b100000), 32'h7777_0000, 32'h1, 32'h1);
        run_vec("R9", mk_i(6'd8, 5'd1, 5'd2, 16'h8000), 32'hFFFF_FFFC, 32'h0, 32'h0);

        // R10: malformed selector fields are ignored.
        run_vec("R10", mk_i(6'd6, 5'd3, 5'd2, 16'h0004), 32'h2000, 32'h0, 32'h0);
        run_vec("R10", mk_i(6'd7, 5'd3, 5'd1, 16'h0004), 32'h2000, 32'h5, 32'h0);
        run_vec("R10", mk_i(6'd1, 5'd3, 5'd2, 16'h0004), 32'h2000, 32'hFFFF_FFFF, 32'h0);
        run_vec("R10", mk_i(6'd1, 5'd3, 5'd17, 16'h0004), 32'h2000, 32'h0, 32'h0);

        // R2: outputs hold between edges while inputs change.
        @(negedge clk);
        instr = mk_i(6'd3, 5'd0, 5'd0, 16'h0040); pc = 32'h1000_0000; rs_val = 0; rt_val = 0;
        ea = model(instr, pc, rs_val, rt_val);
        @(negedge clk);
        instr = mk_r(5'd1, 5'd2, 5'd3, 6'b100100); pc = 32'h2000_0000;
        #1;
        compare("R2", ea);
        @(negedge clk);
        compare("R2", model(instr, pc, rs_val, rt_val));

        // Random mix over all kinds, with malformed variants.
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ins;
            logic [31:0] a;
            logic [31:0] b;
            logic [4:0]  sel;
            a = pick_val();
            b = ($urandom % 4 == 0) ? a : pick_val();
            case ($urandom % 9)
                0: ins = mk_i(6'd4 + 6'($urandom % 2), 5'($urandom), 5'($urandom), 16'($urandom));
                1: ins = mk_i(6'd6 + 6'($urandom % 2), 5'($urandom),
                              ($urandom % 4 == 0) ? 5'($urandom) : 5'd0, 16'($urandom));
                2: begin
                    case ($urandom % 4)
                        0: sel = 5'd0;
                        1: sel = 5'd1;
                        2: sel = 5'd17;
                        default: sel = 5'($urandom);
                    endcase
                    ins = mk_i(6'd1, ($urandom % 2 == 0) ? 5'd0 : 5'($urandom), sel, 16'($urandom));
                end
                3: ins = {6'd2 + 6'($urandom % 2), 26'($urandom)};
                4: ins = mk_r(5'($urandom), 5'($urandom), 5'($urandom), 6'd8 + 6'($urandom % 2));
                5: ins = mk_r(5'($urandom), 5'($urandom), 5'($urandom), 6'($urandom));
                default: ins = $urandom;
            endcase
            run_vec(tag_of(ins), ins, $urandom & 32'hFFFF_FFFC, a, b);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule